// File: doc/BRIEF.md
# Group-Gated Interrupt Eligibility Bank

This block keeps the per-interrupt state for a bank of interrupts. The bank width is a whole number of 32-bit words. For each interrupt it holds six bits: a pending latch, an enable, an active flag, a trigger-mode bit, a group bit and a group-modifier bit. It also samples the raw interrupt input lines through a synchroniser.

From this state, the sampled levels and four global control inputs, it produces a registered mask. A bit of the mask is set when that interrupt may be presented to a processor interface.

Software-side logic updates the latch, enable and active bits through write-one set and clear masks. The trigger, group and modifier words are loaded by a full-word configuration write. Choosing among the eligible interrupts, routing them and decoding a bus are left to neighbouring blocks.

Top module: `irq_elig_bank`

## Requirements
- R1: While reset is asserted, and on the first clock after it, every state bit and every bit of `elig_o` is zero.
- R2: An interrupt whose trigger bit is 0 (level mode) counts as pending while its synchronised input is 1, even with its latch clear. It stops counting once the input returns to 0.
- R3: An interrupt whose trigger bit is 1 (edge mode) sets its pending latch on a 0-to-1 change of its synchronised input. The input level itself is ignored, so the latch stays set after the input falls, and clearing the latch removes eligibility even while the input is held high.
- R4: Each of the six set/clear inputs is a write-one mask. Mask bits at 0 leave the matching state bit unchanged.
- R5: When a set mask and a clear mask hit the same bit of the same state word in one cycle, the bit ends up set.
- R6: An interrupt is eligible only while its enable bit is 1 and its active bit is 0.
- R7: With `en_g1ns_i` high, interrupts whose group bit is 1 are admitted. With it low, no interrupt whose group bit is 1 is eligible.
- R8: `en_g1s_i` admits interrupts with group bit 0 and modifier bit 1.
- R9: `en_g0_i` admits interrupts with group bit 0 and modifier bit 0. With all three group enables low, the mask is all zero.
- R10: While `sec_dis_i` is 1, every modifier bit is treated as 0. Group-0 interrupts are then admitted only by `en_g0_i`.
- R11: `elig_o` is registered. It reflects a change of state (set/clear or configuration write) two clocks after the strobe is driven, and a control change one clock after. A level input change is reflected SYNC_STAGES+1 clocks after it is driven, and an edge-mode latch sets one clock later than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_lvl_i | input | BANK_W | Raw interrupt input levels |
| pend_set_i | input | BANK_W | Write-one mask setting pending latches |
| pend_clr_i | input | BANK_W | Write-one mask clearing pending latches |
| ena_set_i | input | BANK_W | Write-one mask setting enables |
| ena_clr_i | input | BANK_W | Write-one mask clearing enables |
| act_set_i | input | BANK_W | Write-one mask setting active flags |
| act_clr_i | input | BANK_W | Write-one mask clearing active flags |
| cfg_we_i | input | 1 | Loads the three configuration words |
| cfg_edge_i | input | BANK_W | Trigger mode, 1 = edge, 0 = level |
| cfg_grp_i | input | BANK_W | Group bit per interrupt |
| cfg_mod_i | input | BANK_W | Group modifier bit per interrupt |
| sec_dis_i | input | 1 | Security disable: modifiers read as 0 |
| en_g0_i | input | 1 | Admit group 0 |
| en_g1s_i | input | 1 | Admit secure group 1 |
| en_g1ns_i | input | 1 | Admit non-secure group 1 |
| elig_o | output | BANK_W | Registered eligibility mask |

## Verification
The bench builds the bank with BANK_W = 64 and SYNC_STAGES = 2. The 64-bit width puts interrupts in the second word (bits 33 and 40) within reach, which exercises the per-word generate slices beyond the first. The two-stage synchroniser makes the level and edge paths take three and four clocks respectively. This lets the scoreboard tell a correct pipeline depth from one that is a stage short or long, and separates the level-visible cycle from the latch-set cycle.

// File: rtl/irq_elig_pkg.sv
package irq_elig_pkg;

   localparam int unsigned WORD_W = 32;

   typedef struct packed {
      logic sec_dis;
      logic en_g0;
      logic en_g1s;
      logic en_g1ns;
   } grp_ctl_t;

endpackage

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES > 4) begin : g_bad_stages
         $error("irq_in_sync: STAGES must be 0 to 4");
      end

      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] chain_q [STAGES];
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               for (int s = 0; s < int'(STAGES); s++) chain_q[s] <= '0;
            end else begin
               chain_q[0] <= d_i;
               for (int s = 1; s < int'(STAGES); s++) chain_q[s] <= chain_q[s-1];
            end
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/irq_bit_reg.sv
module irq_bit_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] q_q;

   // Set takes precedence over clear on a shared bit.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= '0;
      else         q_q <= (q_q & ~clr_i) | set_i;
   end

   assign q_o = q_q;

   // R5: a bit both set and cleared ends up set
   a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(set_i & clr_i)) |=> ((q_o & $past(set_i & clr_i)) == $past(set_i & clr_i)));

   // R4: bits not named by either mask keep their value
   a_r4_untouched_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((q_o ^ $past(q_o)) & ~$past(set_i | clr_i)) == '0);

endmodule

// File: rtl/irq_group_gate.sv
module irq_group_gate
   import irq_elig_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  grp_ctl_t     ctl_i,
   input  logic [W-1:0] grp_i,
   input  logic [W-1:0] mod_i,
   output logic [W-1:0] admit_o
);

   logic [W-1:0] mod_eff;
   logic [W-1:0] ns1_set;
   logic [W-1:0] s1_set;
   logic [W-1:0] s0_set;

   always_comb begin
      mod_eff = ctl_i.sec_dis ? '0 : mod_i;
      ns1_set = grp_i;
      s1_set  = ~grp_i & mod_eff;
      s0_set  = ~grp_i & ~mod_eff;
      admit_o = ({W{ctl_i.en_g1ns}} & ns1_set)
              | ({W{ctl_i.en_g1s}}  & s1_set)
              | ({W{ctl_i.en_g0}}   & s0_set);
   end

endmodule

// File: rtl/irq_elig_bank.sv
module irq_elig_bank
   import irq_elig_pkg::*;
#(
   parameter int unsigned BANK_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [BANK_W-1:0] irq_lvl_i,
   input  logic [BANK_W-1:0] pend_set_i,
   input  logic [BANK_W-1:0] pend_clr_i,
   input  logic [BANK_W-1:0] ena_set_i,
   input  logic [BANK_W-1:0] ena_clr_i,
   input  logic [BANK_W-1:0] act_set_i,
   input  logic [BANK_W-1:0] act_clr_i,
   input  logic              cfg_we_i,
   input  logic [BANK_W-1:0] cfg_edge_i,
   input  logic [BANK_W-1:0] cfg_grp_i,
   input  logic [BANK_W-1:0] cfg_mod_i,
   input  logic              sec_dis_i,
   input  logic              en_g0_i,
   input  logic              en_g1s_i,
   input  logic              en_g1ns_i,
   output logic [BANK_W-1:0] elig_o
);

   localparam int unsigned NUM_WORDS = BANK_W / WORD_W;

   generate
      if (BANK_W == 0 || (BANK_W % WORD_W) != 0) begin : g_bad_width
         $error("irq_elig_bank: BANK_W must be a non-zero multiple of 32");
      end
   endgenerate

   // Input sampling and edge detection
   logic [BANK_W-1:0] lvl_s;
   logic [BANK_W-1:0] prev_q;
   logic [BANK_W-1:0] rise;

   irq_in_sync #(.W(BANK_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (irq_lvl_i),
      .q_o   (lvl_s)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= lvl_s;
   end

   assign rise = lvl_s & ~prev_q;

   // Configuration words
   logic [BANK_W-1:0] edge_q;
   logic [BANK_W-1:0] grp_q;
   logic [BANK_W-1:0] mod_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         edge_q <= '0;
         grp_q  <= '0;
         mod_q  <= '0;
      end else if (cfg_we_i) begin
         edge_q <= cfg_edge_i;
         grp_q  <= cfg_grp_i;
         mod_q  <= cfg_mod_i;
      end
   end

   // Set/clear state words
   logic [BANK_W-1:0] pend_q;
   logic [BANK_W-1:0] ena_q;
   logic [BANK_W-1:0] act_q;
   logic [BANK_W-1:0] pend_set_all;

   assign pend_set_all = pend_set_i | (rise & edge_q);

   irq_bit_reg #(.W(BANK_W)) u_pend (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(pend_set_all), .clr_i(pend_clr_i), .q_o(pend_q)
   );

   irq_bit_reg #(.W(BANK_W)) u_ena (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(ena_set_i), .clr_i(ena_clr_i), .q_o(ena_q)
   );

   irq_bit_reg #(.W(BANK_W)) u_act (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(act_set_i), .clr_i(act_clr_i), .q_o(act_q)
   );

   // Group admission
   grp_ctl_t          ctl;
   logic [BANK_W-1:0] admit;

   assign ctl = '{sec_dis: sec_dis_i, en_g0: en_g0_i,
                  en_g1s: en_g1s_i, en_g1ns: en_g1ns_i};

   irq_group_gate #(.W(BANK_W)) u_gate (
      .ctl_i  (ctl),
      .grp_i  (grp_q),
      .mod_i  (mod_q),
      .admit_o(admit)
   );

   // Per-word candidate mask and output register
   logic [BANK_W-1:0] cand;

   generate
      for (genvar w = 0; w < int'(NUM_WORDS); w++) begin : g_word
         logic [WORD_W-1:0] raw_w;
         assign raw_w = pend_q[w*WORD_W +: WORD_W]
                      | (~edge_q[w*WORD_W +: WORD_W] & lvl_s[w*WORD_W +: WORD_W]);
         assign cand[w*WORD_W +: WORD_W] = raw_w
                      & ena_q[w*WORD_W +: WORD_W]
                      & ~act_q[w*WORD_W +: WORD_W]
                      & admit[w*WORD_W +: WORD_W];
      end
   endgenerate

   logic [BANK_W-1:0] elig_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) elig_q <= '0;
      else         elig_q <= cand;
   end

   assign elig_o = elig_q;

   // R1: output clear during reset and on the first clock after it
   a_r1_reset_clear: assert property (@(posedge clk_i)
      !rst_ni |=> (elig_o == '0));

   // R6: eligible bits were enabled and not active one clock earlier
   a_r6_enable_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (elig_o & ~$past(ena_q & ~act_q)) == '0);

   // R3: a detected rise on an edge-mode input sets its latch
   a_r3_edge_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(rise & edge_q)) |=> ((pend_q & $past(rise & edge_q)) == $past(rise & edge_q)));

   // R7: without the non-secure group 1 enable, no group-1 interrupt is eligible
   a_r7_ns_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_g1ns_i |=> ((elig_o & $past(grp_q)) == '0));

   // R9: all group enables low empties the mask
   a_r9_all_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_g0_i && !en_g1s_i && !en_g1ns_i) |=> (elig_o == '0));

   // R10: with security disabled, group-0 interrupts need the group 0 enable
   a_r10_secdis: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sec_dis_i && !en_g0_i) |=> ((elig_o & ~$past(grp_q)) == '0));

endmodule

// File: tb/sim_irq_elig_bank.sv
module sim_irq_elig_bank;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 64;
   localparam int SYNC       = 2;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic         rst_n;
   logic [W-1:0] irq_lvl, pend_set, pend_clr, ena_set, ena_clr, act_set, act_clr;
   logic         cfg_we;
   logic [W-1:0] cfg_edge, cfg_grp, cfg_mod;
   logic         sec_dis, en_g0, en_g1s, en_g1ns;
   logic [W-1:0] elig;

   irq_elig_bank #(.BANK_W(W), .SYNC_STAGES(SYNC)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .irq_lvl_i(irq_lvl),
      .pend_set_i(pend_set), .pend_clr_i(pend_clr),
      .ena_set_i(ena_set), .ena_clr_i(ena_clr),
      .act_set_i(act_set), .act_clr_i(act_clr),
      .cfg_we_i(cfg_we), .cfg_edge_i(cfg_edge), .cfg_grp_i(cfg_grp), .cfg_mod_i(cfg_mod),
      .sec_dis_i(sec_dis), .en_g0_i(en_g0), .en_g1s_i(en_g1s), .en_g1ns_i(en_g1ns),
      .elig_o(elig)
   );

   typedef struct {
      logic [W-1:0] val;
      int           due;
      string        tag;
   } item_t;

   item_t sb[$];
   int    cyc = 0;
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // Reference state kept by the bench
   logic [W-1:0] m_pend = '0, m_en = '0, m_act = '0;
   logic [W-1:0] m_edge = '0, m_grp = '0, m_mod = '0, m_lvl = '0;
   logic         m_sd = 0, m_g0 = 0, m_g1s = 0, m_g1ns = 0;

   function automatic logic [W-1:0] model_elig();
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) begin
         logic adm, raw, modv;
         modv = m_mod[i] && !m_sd;
         if (m_grp[i])  adm = m_g1ns;
         else if (modv) adm = m_g1s;
         else           adm = m_g0;
         raw  = m_pend[i] || (!m_edge[i] && m_lvl[i]);
         r[i] = raw && m_en[i] && !m_act[i] && adm;
      end
      return r;
   endfunction

   task automatic push(input logic [W-1:0] v, input int due, input string tag);
      item_t it;
      it.val = v; it.due = due; it.tag = tag;
      sb.push_back(it);
   endtask

   // Monitor: compares the output against queued expectations
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         item_t it;
         it = sb.pop_front();
         n_cmp++;
         if (it.due != cyc || elig !== it.val) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d due %0d)",
                     it.tag, elig, it.val, cyc, it.due);
         end
      end
   end

   task automatic wr_strobe(input logic [W-1:0] ps, pc, es, ec, as_, ac, input string tag);
      logic [W-1:0] old;
      @(negedge clk);
      old = model_elig();
      pend_set = ps; pend_clr = pc; ena_set = es; ena_clr = ec; act_set = as_; act_clr = ac;
      m_pend = (m_pend & ~pc) | ps;
      m_en   = (m_en & ~ec) | es;
      m_act  = (m_act & ~ac) | as_;
      push(old, cyc + 1, {"R11 old value held, ", tag});
      push(model_elig(), cyc + 2, tag);
      @(negedge clk);
      pend_set = '0; pend_clr = '0; ena_set = '0; ena_clr = '0; act_set = '0; act_clr = '0;
      repeat (3) @(negedge clk);
   endtask

   task automatic wr_cfg(input logic [W-1:0] e, g, m, input string tag);
      logic [W-1:0] old;
      @(negedge clk);
      old = model_elig();
      cfg_we = 1'b1; cfg_edge = e; cfg_grp = g; cfg_mod = m;
      m_edge = e; m_grp = g; m_mod = m;
      push(old, cyc + 1, {"R11 old value held, ", tag});
      push(model_elig(), cyc + 2, tag);
      @(negedge clk);
      cfg_we = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic set_ctl(input logic sd, g0, g1s, g1ns, input string tag);
      @(negedge clk);
      sec_dis = sd; en_g0 = g0; en_g1s = g1s; en_g1ns = g1ns;
      m_sd = sd; m_g0 = g0; m_g1s = g1s; m_g1ns = g1ns;
      push(model_elig(), cyc + 1, tag);
      repeat (3) @(negedge clk);
   endtask

   task automatic set_in(input logic [W-1:0] v, input string tag);
      logic [W-1:0] old, rises, mid;
      @(negedge clk);
      old   = model_elig();
      rises = v & ~m_lvl & m_edge;
      irq_lvl = v;
      m_lvl = v;
      mid   = model_elig();
      m_pend = m_pend | rises;
      push(old, cyc + SYNC, {"R11 synchroniser delay, ", tag});
      push(mid, cyc + SYNC + 1, tag);
      push(model_elig(), cyc + SYNC + 2, tag);
      repeat (SYNC + 4) @(negedge clk);
   endtask

   localparam logic [W-1:0] B0  = 64'h1;
   localparam logic [W-1:0] B3  = 64'h1 << 3;
   localparam logic [W-1:0] B5  = 64'h1 << 5;
   localparam logic [W-1:0] B20 = 64'h1 << 20;
   localparam logic [W-1:0] B33 = 64'h1 << 33;
   localparam logic [W-1:0] B40 = 64'h1 << 40;
   localparam logic [W-1:0] Z   = '0;

   initial begin
      rst_n = 1'b0;
      irq_lvl = '0; pend_set = '0; pend_clr = '0; ena_set = '0; ena_clr = '0;
      act_set = '0; act_clr = '0; cfg_we = 1'b0; cfg_edge = '0; cfg_grp = '0; cfg_mod = '0;
      sec_dis = 1'b0; en_g0 = 1'b0; en_g1s = 1'b0; en_g1ns = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      push('0, cyc + 1, "R1 reset state");
      repeat (2) @(negedge clk);

      set_ctl(0, 0, 0, 1, "R7 group 1 ns open, nothing pending");
      wr_cfg(Z, {W{1'b1}}, Z, "R7 all group 1");
      wr_strobe(B5, Z, B0 | B5 | B40, Z, Z, Z, "R4 R7 set pending and enables");
      set_in(B0, "R2 level input raises eligibility");
      set_in(Z, "R2 level input falls, eligibility drops");
      wr_strobe(Z, Z, Z, Z, B5, Z, "R6 active blocks");
      wr_strobe(Z, Z, Z, Z, Z, B5, "R6 active cleared");
      wr_strobe(Z, Z, Z, B5, Z, Z, "R6 enable cleared");
      wr_strobe(Z, Z, B5, Z, Z, Z, "R4 pending kept while disabled");
      wr_strobe(B40, Z, Z, Z, Z, Z, "R4 zero mask bits unchanged");
      wr_strobe(B5, B5 | B40, Z, Z, Z, Z, "R5 set wins over clear");

      wr_cfg(Z, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_0000_FFFF, "R7 lower word group 0");
      wr_strobe(B3 | B20, Z, B3 | B20, Z, Z, Z, "R7 group 0 blocked by ns enable only");
      set_ctl(0, 0, 1, 0, "R8 secure group 1 enable");
      set_ctl(0, 1, 0, 0, "R9 group 0 enable");
      set_ctl(0, 0, 0, 0, "R9 all groups closed");
      set_ctl(1, 0, 1, 0, "R10 security disable drops modifier");
      set_ctl(1, 1, 0, 0, "R10 group 0 admits modifier 1 under disable");

      set_ctl(0, 0, 0, 1, "R7 back to ns group");
      wr_cfg(B33, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_0000_FFFF, "R3 edge mode on bit 33");
      wr_strobe(Z, Z, B33, Z, Z, Z, "R3 enable edge interrupt");
      set_in(B33, "R3 rising edge latches");
      set_in(Z, "R3 latch holds after fall");
      set_in(B33, "R3 second rise");
      wr_strobe(Z, B33, Z, Z, Z, Z, "R3 level ignored in edge mode");

      wait (sb.size() == 0);
      repeat (2) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R11 watchdog actual=hung expected=complete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule